// File: doc/BRIEF.md
# Queued Command and Data Front-End for a Serial Transfer Engine

This block sits between a simple host register bus and a serial transfer engine, for example an I2C master. It supplies the engine with command words and transmit bytes, and it takes back the bytes the engine receives. It can work in two ways. In direct mode the host loads a single command and starts it. After that, each data byte moves only when the host answers a data-request flag. A completion flag marks the end of the command.

In queue mode the host first loads commands and transmit bytes into separate FIFOs. It then sets a run bit. From that point the front-end issues the commands to the engine one after another with no polling. It feeds transmit bytes out of the transmit FIFO and stores received bytes in a receive FIFO. The host reads that FIFO through its own register, apart from the transmit register. A completion interrupt is raised when the command queue runs dry while run is set.

Register map (word addresses): 0 = mode (bit0 queue mode, bit1 queue run); 1 = direct command; 2 = flags; 3 = queued command; 4 = transmit data on write and direct receive byte on read; 5 = queued receive data; 6 = status. The flags register holds: bit0 run/start, bit1 data request, bit2 completion, bit3 overflow, bit4 underflow. The status register holds: bits [3:0] command FIFO level, [7:4] transmit FIFO level, [11:8] receive FIFO level, bit12 busy (default parameters).

Top module: `qfe_top`

## Requirements
- R1: After reset, the mode, flags and status registers read zero, `irq` is low and `eng_start` is low.
- R2: In direct mode, writing 1 to flags bit0 gives a one-cycle `eng_start` pulse that carries the direct command. Flags bit0 then reads 1 until `eng_done`. At `eng_done`, flags bit2 and `irq` are set.
- R3: In direct mode, an engine request sets flags bit1. For a read request, it also captures `eng_rx_data` into address 4. `eng_xfer_ack` pulses only after the host writes 1 to flags bit1, and `eng_tx_data` then carries the byte last written to address 4.
- R4: In queue mode, writes to addresses 3 and 4 go into the command and transmit FIFOs. No command reaches the engine while the queue-run bit is 0.
- R5: Queued commands reach the engine in write order, one at a time. The next `eng_start` comes only after `eng_done` for the previous command.
- R6: In queue mode, write requests receive transmit-FIFO bytes in order. Read requests push `eng_rx_data` into the receive FIFO, and reads of address 5 return those bytes in order.
- R7: Clearing the queue-run bit lets the current command finish but stops any further dispatch. Setting it again resumes dispatch.
- R8: When a queued command completes with the command FIFO empty and queue run set, flags bit2 and `irq` go high. They stay high until the host writes 1 to flags bit2.
- R9: A queued write to a full FIFO is dropped and sets the sticky flags bit3. Writing 1 to bit3 clears it.
- R10: Reading address 5 while the receive FIFO is empty returns 0 and sets the sticky flags bit4. Writing 1 to bit4 clears it.
- R11: The status register reports the three FIFO levels and a busy bit that is 1 from dispatch until `eng_done`.
- R12: With queue mode clear, a write to address 3 loads the direct command (read back at address 1). With queue mode set, a direct start written to flags bit0 is ignored.
- R13: In queue mode, an engine write request with the transmit FIFO empty gets no acknowledge. It is served once a byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops at address 5) |
| host_addr | input | 3 | Register word address |
| host_wdata | input | CMD_W | Host write data |
| host_rdata | output | CMD_W | Host read data, combinational from address |
| irq | output | 1 | Completion interrupt (flags bit2) |
| eng_start | output | 1 | One-cycle command start to the engine |
| eng_cmd | output | CMD_W | Command word for the engine |
| eng_done | input | 1 | Engine pulse: current command finished |
| eng_xfer_req | input | 1 | Engine wants a data byte exchanged (held until acknowledged) |
| eng_xfer_rd | input | 1 | 1 = engine delivers a received byte, 0 = engine needs a transmit byte |
| eng_rx_data | input | DATA_W | Received byte from the engine |
| eng_xfer_ack | output | 1 | One-cycle acknowledge of a data exchange |
| eng_tx_data | output | DATA_W | Transmit byte, valid with the acknowledge |

## Verification
Several behaviours are checked by assertions on every cycle. The start pulse is always a single cycle. Busy holds until the engine reports done. A queued dispatch never happens without queue run, and a direct dispatch never happens in queue mode. The acknowledge is a single pulse that follows an engine request. The completion interrupt stays set until the host clears it. A read of an empty receive FIFO raises underflow. FIFO levels stay bounded, and a full FIFO ignores pushes. Other behaviours can only be shown by the bench scenarios, because they depend on sequence and content. These are the order and values of commands and bytes seen by the engine, the drop of the ninth queued byte, the stop-and-resume effect of clearing queue run, and the stalled acknowledge that waits until a transmit byte arrives.

// File: rtl/qfe_pkg.sv
`timescale 1ns/1ps
package qfe_pkg;
    // register word addresses
    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_DCMD = 3'd1;
    localparam logic [2:0] RA_FLAG = 3'd2;
    localparam logic [2:0] RA_QCMD = 3'd3;
    localparam logic [2:0] RA_TXD  = 3'd4;
    localparam logic [2:0] RA_RXQ  = 3'd5;
    localparam logic [2:0] RA_STAT = 3'd6;
    // flag bit positions
    localparam int FB_GO   = 0;
    localparam int FB_DREQ = 1;
    localparam int FB_CMPL = 2;
    localparam int FB_OVF  = 3;
    localparam int FB_UDF  = 4;
    // mode bit positions
    localparam int MB_QMODE = 0;
    localparam int MB_QRUN  = 1;
endpackage

// File: rtl/qfe_fifo.sv
`timescale 1ns/1ps
module qfe_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH):0]       level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == LW'(DEPTH));
    assign level = q.cnt;
    assign rdata = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R11: level never exceeds the depth
    p_level_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LW'(DEPTH));
    // R9: a push into a full FIFO without a pop leaves it full
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full);
    // R10: a pop from an empty FIFO without a push leaves it empty
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty);
endmodule

// File: rtl/qfe_dispatch.sv
`timescale 1ns/1ps
module qfe_dispatch #(
    parameter int CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qmode,
    input  logic             qrun,
    input  logic             dir_go,
    input  logic [CMD_W-1:0] dir_cmd,
    input  logic [CMD_W-1:0] q_cmd,
    input  logic             q_empty,
    output logic             q_pop,
    input  logic             eng_done,
    output logic             eng_start,
    output logic [CMD_W-1:0] eng_cmd,
    output logic             busy,
    output logic             run,
    output logic             done_evt,
    output logic             drained
);
    typedef struct packed {
        logic             busy;
        logic             run;
        logic             src;    // 1 = command came from the queue
        logic             start;
        logic [CMD_W-1:0] cmd;
    } disp_st_t;

    disp_st_t q, d;

    assign eng_start = q.start;
    assign eng_cmd   = q.cmd;
    assign busy      = q.busy;
    assign run       = q.run;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        q_pop    = 1'b0;
        done_evt = 1'b0;
        drained  = 1'b0;
        if (q.busy) begin
            if (eng_done) begin
                d.busy = 1'b0;
                d.run  = 1'b0;
                if (!q.src)                done_evt = 1'b1;
                else if (qrun && q_empty)  drained  = 1'b1;
            end
        end else if (!qmode && dir_go) begin
            d.busy  = 1'b1;
            d.run   = 1'b1;
            d.src   = 1'b0;
            d.start = 1'b1;
            d.cmd   = dir_cmd;
        end else if (qmode && qrun && !q_empty) begin
            q_pop   = 1'b1;
            d.busy  = 1'b1;
            d.src   = 1'b1;
            d.start = 1'b1;
            d.cmd   = q_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: start is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |=> !q.start);
    // R5: a start always coincides with busy
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> q.busy);
    // R5: busy holds until the engine reports done
    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && !eng_done |=> q.busy);
    // R4: a queued dispatch needs queue run in the cycle before
    p_queue_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.start && q.src |-> $past(qrun));
    // R12: a direct dispatch happens only outside queue mode
    p_direct_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        q.start && !q.src |-> $past(!qmode));
endmodule

// File: rtl/qfe_top.sv
`timescale 1ns/1ps
module qfe_top
    import qfe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CMD_W  = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [CMD_W-1:0]  host_wdata,
    output logic [CMD_W-1:0]  host_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic [CMD_W-1:0]  eng_cmd,
    input  logic              eng_done,
    input  logic              eng_xfer_req,
    input  logic              eng_xfer_rd,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_xfer_ack,
    output logic [DATA_W-1:0] eng_tx_data
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic              qmode;
        logic              qrun;
        logic [CMD_W-1:0]  dcmd;
        logic [DATA_W-1:0] dtx;
        logic [DATA_W-1:0] drx;
        logic              dreq;
        logic              cmpl;
        logic              ovf;
        logic              udf;
        logic              ack;
        logic [DATA_W-1:0] txd;
    } top_st_t;

    top_st_t q, d;

    logic              dir_go, clr_dreq;
    logic              cmd_push, cmd_pop, cmd_empty, cmd_full;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [CMD_W-1:0]  cmd_rdata;
    logic [DATA_W-1:0] tx_rdata, rx_rdata;
    logic [LVL_W-1:0]  cmd_lvl, tx_lvl, rx_lvl;
    logic              busy, run, done_evt, drained;

    qfe_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(host_wdata),
        .pop(cmd_pop), .rdata(cmd_rdata), .empty(cmd_empty), .full(cmd_full),
        .level(cmd_lvl));

    qfe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(host_wdata[DATA_W-1:0]),
        .pop(tx_pop), .rdata(tx_rdata), .empty(tx_empty), .full(tx_full),
        .level(tx_lvl));

    qfe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(eng_rx_data),
        .pop(rx_pop), .rdata(rx_rdata), .empty(rx_empty), .full(rx_full),
        .level(rx_lvl));

    qfe_dispatch #(.CMD_W(CMD_W)) u_dispatch (
        .clk(clk), .rst_n(rst_n), .qmode(q.qmode), .qrun(q.qrun),
        .dir_go(dir_go), .dir_cmd(q.dcmd), .q_cmd(cmd_rdata), .q_empty(cmd_empty),
        .q_pop(cmd_pop), .eng_done(eng_done), .eng_start(eng_start),
        .eng_cmd(eng_cmd), .busy(busy), .run(run), .done_evt(done_evt),
        .drained(drained));

    assign irq          = q.cmpl;
    assign eng_xfer_ack = q.ack;
    assign eng_tx_data  = q.txd;

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        dir_go   = 1'b0;
        cmd_push = 1'b0;
        tx_push  = 1'b0;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        rx_pop   = 1'b0;
        clr_dreq = host_wr && (host_addr == RA_FLAG) && host_wdata[FB_DREQ];

        // host register writes
        if (host_wr) begin
            case (host_addr)
                RA_MODE: begin
                    d.qmode = host_wdata[MB_QMODE];
                    d.qrun  = host_wdata[MB_QRUN];
                end
                RA_DCMD: d.dcmd = host_wdata;
                RA_FLAG: begin
                    dir_go = host_wdata[FB_GO];
                    if (host_wdata[FB_CMPL]) d.cmpl = 1'b0;
                    if (host_wdata[FB_OVF])  d.ovf  = 1'b0;
                    if (host_wdata[FB_UDF])  d.udf  = 1'b0;
                end
                RA_QCMD: begin
                    if (!q.qmode)     d.dcmd   = host_wdata;
                    else if (cmd_full) d.ovf   = 1'b1;
                    else               cmd_push = 1'b1;
                end
                RA_TXD: begin
                    if (!q.qmode)     d.dtx   = host_wdata[DATA_W-1:0];
                    else if (tx_full)  d.ovf   = 1'b1;
                    else               tx_push = 1'b1;
                end
                default: ;
            endcase
        end

        // host pop of queued receive data
        if (host_rd && (host_addr == RA_RXQ)) begin
            if (rx_empty) d.udf  = 1'b1;
            else          rx_pop = 1'b1;
        end

        // engine data handshake
        if (!q.qmode) begin
            if (q.dreq && clr_dreq) begin
                d.dreq = 1'b0;
                d.ack  = eng_xfer_req;
                d.txd  = q.dtx;
            end else if (!q.dreq && eng_xfer_req && !q.ack) begin
                d.dreq = 1'b1;
                if (eng_xfer_rd) d.drx = eng_rx_data;
            end
        end else begin
            if (clr_dreq) d.dreq = 1'b0;
            if (eng_xfer_req && !q.ack) begin
                if (eng_xfer_rd) begin
                    if (!rx_full) begin
                        rx_push = 1'b1;
                        d.ack   = 1'b1;
                    end
                end else if (!tx_empty) begin
                    tx_pop = 1'b1;
                    d.txd  = tx_rdata;
                    d.ack  = 1'b1;
                end
            end
        end

        // completion
        if (done_evt || drained) d.cmpl = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (host_addr)
            RA_MODE: host_rdata = CMD_W'({q.qrun, q.qmode});
            RA_DCMD: host_rdata = q.dcmd;
            RA_FLAG: host_rdata = CMD_W'({q.udf, q.ovf, q.cmpl, q.dreq, run});
            RA_TXD:  host_rdata = CMD_W'(q.drx);
            RA_RXQ:  host_rdata = rx_empty ? '0 : CMD_W'(rx_rdata);
            RA_STAT: host_rdata = CMD_W'({busy, rx_lvl, tx_lvl, cmd_lvl});
            default: host_rdata = '0;
        endcase
    end

    // R3: acknowledge is a single pulse
    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_xfer_ack |=> !eng_xfer_ack);
    // R3: acknowledge only answers an engine request
    p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_xfer_ack |-> $past(eng_xfer_req));
    // R3: in direct mode the request flag holds until the host clears it
    p_dreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.dreq && !q.qmode && !clr_dreq |=> q.dreq);
    // R8: completion interrupt is sticky until written with one
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(host_wr && host_addr == RA_FLAG && host_wdata[FB_CMPL]) |=> irq);
    // R10: reading an empty receive queue raises underflow
    p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == RA_RXQ && rx_empty |=> q.udf);
endmodule

// File: tb/tb_qfe_top.sv
`timescale 1ns/1ps
module tb_qfe_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq, eng_start, eng_xfer_ack;
    logic [15:0] eng_cmd;
    logic        eng_done, eng_xfer_req, eng_xfer_rd;
    logic [7:0]  eng_rx_data, eng_tx_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // engine model bookkeeping
    logic [15:0] cmd_log [64];
    logic [7:0]  tx_log  [64];
    int          n_cmd = 0, n_tx = 0, viol = 0, done_dly = 2;
    logic [7:0]  rx_next = 8'hA0;

    always #4 clk = ~clk;   // 125 MHz

    qfe_top dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .eng_start(eng_start), .eng_cmd(eng_cmd), .eng_done(eng_done),
        .eng_xfer_req(eng_xfer_req), .eng_xfer_rd(eng_xfer_rd),
        .eng_rx_data(eng_rx_data), .eng_xfer_ack(eng_xfer_ack),
        .eng_tx_data(eng_tx_data));

    // engine model: cmd[15:12] = byte count, cmd[11] = 1 for read
    initial begin
        logic [15:0] cur;
        eng_done = 1'b0; eng_xfer_req = 1'b0; eng_xfer_rd = 1'b0; eng_rx_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && eng_start) begin
                cur = eng_cmd;
                cmd_log[n_cmd] = cur;
                n_cmd++;
                for (int k = 0; k < int'(cur[15:12]); k++) begin
                    eng_xfer_req = 1'b1;
                    eng_xfer_rd  = cur[11];
                    eng_rx_data  = rx_next;
                    do begin
                        @(negedge clk);
                        if (eng_start) viol++;
                    end while (!eng_xfer_ack);
                    if (cur[11]) rx_next++;
                    else begin
                        tx_log[n_tx] = eng_tx_data;
                        n_tx++;
                    end
                    eng_xfer_req = 1'b0;
                end
                for (int k = 0; k < done_dly; k++) begin
                    @(negedge clk);
                    if (eng_start) viol++;
                end
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1; break; end
        end
    endtask

    task automatic wait_dreq(output logic [15:0] fl);
        fl = '0;
        for (int i = 0; i < 50; i++) begin
            rd(3'd2, fl);
            if (fl[1]) break;
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); chk("R1 mode reg", v, 0);
        rd(3'd2, v); chk("R1 flags reg", v, 0);
        rd(3'd6, v); chk("R1 status reg", v, 0);
        chk("R1 irq/start", {irq, eng_start}, 0);
    endtask

    task automatic t_direct_write;
        logic [15:0] v; bit ok; int b;
        b = n_tx;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'h1012);
        wr(3'd4, 16'h005A);
        wr(3'd2, 16'h0001);
        wait_dreq(v);
        chk("R2 run and R3 dreq set", v, 16'h0003);
        chk("R3 no ack before clear", n_tx - b, 0);
        chk("R2 direct cmd issued", cmd_log[n_cmd-1], 16'h1012);
        chk("R2 irq low while running", irq, 0);
        wr(3'd2, 16'h0002);
        wait_irq(ok);
        chk("R2 completion irq", ok, 1);
        chk("R3 tx byte after clear", tx_log[b], 8'h5A);
        rd(3'd2, v); chk("R2 run cleared, cmpl set", v, 16'h0004);
        wr(3'd2, 16'h0004);
        rd(3'd2, v); chk("R8 cmpl cleared", {irq, v}, 0);
    endtask

    task automatic t_direct_read;
        logic [15:0] v; bit ok;
        wr(3'd1, 16'h1800);
        wr(3'd2, 16'h0001);
        wait_dreq(v);
        rd(3'd4, v); chk("R3 captured rx byte", v, 16'h00A0);
        wr(3'd2, 16'h0002);
        wait_irq(ok);
        chk("R2 read cmd completes", ok, 1);
        wr(3'd2, 16'h0004);
    endtask

    task automatic t_mode_routing;
        logic [15:0] v; int b;
        wr(3'd0, 16'h0);
        wr(3'd3, 16'h2222);
        rd(3'd1, v); chk("R12 qcmd write loads direct cmd", v, 16'h2222);
        wr(3'd0, 16'h1);
        b = n_cmd;
        wr(3'd2, 16'h0001);
        repeat (10) @(negedge clk);
        chk("R12 direct start ignored in queue mode", n_cmd - b, 0);
        rd(3'd2, v); chk("R12 run stays low", v, 0);
    endtask

    task automatic t_queue_flow;
        logic [15:0] v; bit ok; int bc, bt;
        bc = n_cmd; bt = n_tx;
        wr(3'd0, 16'h1);
        wr(3'd3, 16'h2001);
        wr(3'd3, 16'h2802);
        wr(3'd3, 16'h1003);
        wr(3'd4, 16'h11);
        wr(3'd4, 16'h22);
        wr(3'd4, 16'h33);
        repeat (10) @(negedge clk);
        chk("R4 nothing dispatched before run", n_cmd - bc, 0);
        rd(3'd6, v); chk("R11 levels cmd=3 tx=3", v, 16'h0033);
        wr(3'd0, 16'h3);
        wait_irq(ok);
        chk("R8 drain irq", ok, 1);
        chk("R5 cmd count", n_cmd - bc, 3);
        chk("R5 order 0", cmd_log[bc], 16'h2001);
        chk("R5 order 1", cmd_log[bc+1], 16'h2802);
        chk("R5 order 2", cmd_log[bc+2], 16'h1003);
        chk("R6 tx bytes", {tx_log[bt], tx_log[bt+1], tx_log[bt+2]}, 24'h112233);
        rd(3'd6, v); chk("R11 rx level 2", v, 16'h0200);
        rd(3'd5, v); chk("R6 rx first", v, 16'h00A1);
        rd(3'd5, v); chk("R6 rx second", v, 16'h00A2);
        repeat (5) @(negedge clk);
        chk("R8 irq sticky", irq, 1);
        wr(3'd2, 16'h0004);
        chk("R8 irq cleared", irq, 0);
        chk("R5 no overlapping start", viol, 0);
        wr(3'd0, 16'h1);
    endtask

    task automatic t_stop_resume;
        logic [15:0] v; bit ok; int b;
        done_dly = 20;
        wr(3'd0, 16'h1);
        wr(3'd3, 16'h0001);
        wr(3'd3, 16'h0002);
        b = n_cmd;
        wr(3'd0, 16'h3);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (n_cmd > b) break;
        end
        wr(3'd0, 16'h1);
        repeat (60) @(negedge clk);
        chk("R7 only one cmd after stop", n_cmd - b, 1);
        rd(3'd6, v); chk("R7 one cmd left, idle", v, 16'h0001);
        chk("R7 no irq after stop", irq, 0);
        wr(3'd0, 16'h3);
        wait_irq(ok);
        chk("R7 resume dispatches rest", n_cmd - b, 2);
        wr(3'd2, 16'h0004);
        wr(3'd0, 16'h1);
        done_dly = 2;
    endtask

    task automatic t_overflow;
        logic [15:0] v; bit ok; int b;
        b = n_tx;
        wr(3'd0, 16'h1);
        for (int i = 0; i < 9; i++) wr(3'd4, 16'(16'h40 + i));
        rd(3'd6, v); chk("R11 tx level full", v, 16'h0080);
        rd(3'd2, v); chk("R9 overflow set", v, 16'h0008);
        wr(3'd2, 16'h0008);
        rd(3'd2, v); chk("R9 overflow cleared", v, 0);
        wr(3'd3, 16'h8004);
        wr(3'd0, 16'h3);
        wait_irq(ok);
        chk("R9 eight bytes sent", n_tx - b, 8);
        chk("R9 ninth byte dropped", tx_log[b+7], 8'h47);
        wr(3'd2, 16'h0004);
        wr(3'd0, 16'h1);
    endtask

    task automatic t_underflow;
        logic [15:0] v;
        rd(3'd5, v); chk("R10 empty read is zero", v, 0);
        rd(3'd2, v); chk("R10 underflow set", v, 16'h0010);
        wr(3'd2, 16'h0010);
        rd(3'd2, v); chk("R10 underflow cleared", v, 0);
    endtask

    task automatic t_stall;
        logic [15:0] v; bit ok; int b;
        b = n_tx;
        wr(3'd0, 16'h1);
        wr(3'd3, 16'h1005);
        wr(3'd0, 16'h3);
        repeat (20) @(negedge clk);
        chk("R13 no ack with empty tx", n_tx - b, 0);
        rd(3'd6, v); chk("R11 busy while stalled", v, 16'h1000);
        wr(3'd4, 16'h0077);
        wait_irq(ok);
        chk("R13 served after byte arrives", tx_log[b], 8'h77);
        wr(3'd2, 16'h0004);
        wr(3'd0, 16'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct_write();
        t_direct_read();
        t_mode_routing();
        t_queue_flow();
        t_stop_resume();
        t_overflow();
        t_underflow();
        t_stall();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule